// File: doc/BRIEF.md
# Cache Snoop Inquiry Responder

This block answers inquiry cycles that another bus master starts against the processor's internal cache. While the processor has released its address bus, the system pulls an active-low inquiry strobe and drives the snooped address together with an invalidate qualifier. The block captures both, asks the tag array for the line state and checks the line held in the copy-back buffer. A fixed two clocks after the strobe is sampled it reports whether a Modified copy was found.

When a Modified copy is found, the block raises a write-back request and holds the hit-modified flag until the bus interface reports the write-back done. For a line present in the cache it also issues a one-cycle state update. The line becomes Invalid when the inquiring master writes and Shared when it reads. The tag array is outside the block: the block gives it a line address and a lookup enable, and reads back a hit flag and the stored state one clock later. Write buffers holding write-miss data are not compared.

Top module: `snoop_inquiry_resp`

## Requirements
- R1: After reset, lookupEn, hitMod, wbReq, wbFromBuf and updValid are all 0.
- R2: A low extStrobeN is accepted only while (holdReq and holdAck are both 1), or backOff is 1, or addrHold is 1. In every other case it is ignored: no lookup, no hit report, no update.
- R3: After an accepted strobe edge, lookupEn is 1 for exactly the next cycle, and lookupAddr carries the captured snoopAddr with the low OFFSET_W bits removed. tagHit and tagState are sampled at the end of that cycle.
- R4: hitMod is 0 in the cycle after the lookup cycle. From the second edge after the strobe edge it is 1 if tagHit was 1 with tagState 2'b11 (Modified), or if cbValid was 1 with cbAddr on the same line. Otherwise it is 0. State codes are Invalid 2'b00, Shared 2'b01, Exclusive 2'b10 and Modified 2'b11.
- R5: The copy-back buffer comparison ignores the low OFFSET_W (4) byte-offset bits of both addresses, and a buffer with cbValid 0 never matches.
- R6: When tagHit was 1, updValid pulses for one cycle together with the hit report. updAddr is the line address and updState is 2'b00 if the invalidate qualifier was 1, or 2'b01 if it was 0. When tagHit was 0, no pulse is issued.
- R7: On a Modified hit, wbReq rises with hitMod. wbFromBuf is 1 when only the buffer matched. hitMod and wbReq both stay 1 until wbDone is sampled 1, and they are 0 after that edge.
- R8: A strobe that arrives while an inquiry is in progress is ignored. This covers the capture, lookup and result cycles and the whole write-back wait.
- R9: invReq is sampled only in the strobe cycle; later changes have no effect on updState.
- R10: wbDone has no effect unless a write-back is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| holdReq | input | 1 | Bus hold request from the system |
| holdAck | input | 1 | Hold acknowledge from the processor |
| backOff | input | 1 | Back-off: processor forced off the bus |
| addrHold | input | 1 | Address hold: address bus floated for the system |
| extStrobeN | input | 1 | Active-low external inquiry strobe |
| invReq | input | 1 | Invalidate qualifier (1 = other master writes) |
| snoopAddr | input | ADDR_W | Snooped byte address |
| lookupEn | output | 1 | Tag array lookup enable |
| lookupAddr | output | ADDR_W-OFFSET_W | Line address for the tag lookup |
| tagHit | input | 1 | Tag lookup hit |
| tagState | input | 2 | State of the hit line |
| cbValid | input | 1 | Copy-back buffer holds a line |
| cbAddr | input | ADDR_W | Address of the copy-back buffer line |
| wbDone | input | 1 | Write-back of the hit line completed |
| hitMod | output | 1 | Modified copy found |
| wbReq | output | 1 | Write-back request |
| wbFromBuf | output | 1 | Write-back source is the copy-back buffer |
| updValid | output | 1 | One-cycle line state update strobe |
| updAddr | output | ADDR_W-OFFSET_W | Line address of the update |
| updState | output | 2 | New line state |

## Verification
There are two pairs of events that can fall in the same cycle. The first is a new inquiry strobe arriving while the result or write-back wait of the previous inquiry is still open. The second is a wbDone pulse arriving in a cycle where no write-back is pending. The bench provokes both on purpose, in both directed and random inquiries. It pulls the strobe low again with a legal hold condition in the result cycle and on every cycle of the write-back wait, and it pulses wbDone during the lookup cycle and after inquiries that found no Modified copy. Each case is judged at the ports: lookupEn must stay 0, the hit flag and request must keep their values until the real completion, and no extra update pulse may appear.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    LINE_I = 2'b00,
    LINE_S = 2'b01,
    LINE_E = 2'b10,
    LINE_M = 2'b11
  } lineState_e;

  typedef struct packed {
    logic capture;   // take address and qualifier
    logic latchRes;  // sample tag result and buffer compare
    logic issue;     // drive hit report, update and request
    logic freeWb;    // write-back finished
  } snoopCtrl_t;
endpackage

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdReq,
  input  logic       holdAck,
  input  logic       backOff,
  input  logic       addrHold,
  input  logic       strobeSeen,
  input  logic       wbDone,
  input  logic       modHit,
  output snoopCtrl_t ctrl,
  output logic       lookupEn
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_EVAL, S_WAIT} phase_e;
  phase_e phase, phaseNext;
  logic busReleased;

  assign busReleased = (holdReq && holdAck) || backOff || addrHold;

  always_comb begin
    ctrl          = '0;
    ctrl.capture  = (phase == S_IDLE) && strobeSeen && busReleased;
    ctrl.latchRes = (phase == S_LOOK);
    ctrl.issue    = (phase == S_EVAL);
    ctrl.freeWb   = (phase == S_WAIT) && wbDone;
  end

  always_comb begin
    phaseNext = phase;
    case (phase)
      S_IDLE: if (ctrl.capture) phaseNext = S_LOOK;
      S_LOOK: phaseNext = S_EVAL;
      S_EVAL: phaseNext = modHit ? S_WAIT : S_IDLE;
      S_WAIT: if (wbDone) phaseNext = S_IDLE;
      default: phaseNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= S_IDLE;
    else       phase <= phaseNext;
  end

  assign lookupEn = (phase == S_LOOK);
endmodule

// File: rtl/snoop_dp.sv
module snoop_dp
  import snoop_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  snoopCtrl_t                 ctrl,
  input  logic [ADDR_W-1:0]          snoopAddr,
  input  logic                       invReq,
  input  logic                       tagHit,
  input  logic [1:0]                 tagState,
  input  logic                       cbValid,
  input  logic [ADDR_W-1:0]          cbAddr,
  output logic                       modHit,
  output logic [ADDR_W-OFFSET_W-1:0] lookupAddr,
  output logic                       hitMod,
  output logic                       wbReq,
  output logic                       wbFromBuf,
  output logic                       updValid,
  output logic [ADDR_W-OFFSET_W-1:0] updAddr,
  output logic [1:0]                 updState
);
  localparam int LINE_W = ADDR_W - OFFSET_W;
  localparam logic [ADDR_W-1:0] LINE_MASK = {{LINE_W{1'b1}}, {OFFSET_W{1'b0}}};

  logic [ADDR_W-1:0] addrR;
  logic invR, tagHitR, cacheModR, bufHitR;
  logic bufMatch;

  assign bufMatch   = cbValid && (((cbAddr ^ addrR) & LINE_MASK) == '0);
  assign lookupAddr = addrR[ADDR_W-1:OFFSET_W];
  assign modHit     = cacheModR || bufHitR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR <= '0;
      invR  <= 1'b0;
    end else if (ctrl.capture) begin
      addrR <= snoopAddr;
      invR  <= invReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagHitR   <= 1'b0;
      cacheModR <= 1'b0;
      bufHitR   <= 1'b0;
    end else if (ctrl.latchRes) begin
      tagHitR   <= tagHit;
      cacheModR <= tagHit && (tagState == LINE_M);
      bufHitR   <= bufMatch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitMod    <= 1'b0;
      wbReq     <= 1'b0;
      wbFromBuf <= 1'b0;
    end else if (ctrl.issue) begin
      hitMod    <= modHit;
      wbReq     <= modHit;
      wbFromBuf <= bufHitR && !cacheModR;
    end else if (ctrl.freeWb) begin
      hitMod    <= 1'b0;
      wbReq     <= 1'b0;
      wbFromBuf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updValid <= 1'b0;
      updAddr  <= '0;
      updState <= LINE_I;
    end else begin
      updValid <= ctrl.issue && tagHitR;
      if (ctrl.issue) begin
        updAddr  <= addrR[ADDR_W-1:OFFSET_W];
        updState <= invR ? LINE_I : LINE_S;
      end
    end
  end
endmodule

// File: rtl/snoop_inquiry_resp.sv
module snoop_inquiry_resp
  import snoop_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       holdReq,
  input  logic                       holdAck,
  input  logic                       backOff,
  input  logic                       addrHold,
  input  logic                       extStrobeN,
  input  logic                       invReq,
  input  logic [ADDR_W-1:0]          snoopAddr,
  output logic                       lookupEn,
  output logic [ADDR_W-OFFSET_W-1:0] lookupAddr,
  input  logic                       tagHit,
  input  logic [1:0]                 tagState,
  input  logic                       cbValid,
  input  logic [ADDR_W-1:0]          cbAddr,
  input  logic                       wbDone,
  output logic                       hitMod,
  output logic                       wbReq,
  output logic                       wbFromBuf,
  output logic                       updValid,
  output logic [ADDR_W-OFFSET_W-1:0] updAddr,
  output logic [1:0]                 updState
);
  snoopCtrl_t ctrl;
  logic modHit;

  snoop_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .holdReq    (holdReq),
    .holdAck    (holdAck),
    .backOff    (backOff),
    .addrHold   (addrHold),
    .strobeSeen (!extStrobeN),
    .wbDone     (wbDone),
    .modHit     (modHit),
    .ctrl       (ctrl),
    .lookupEn   (lookupEn)
  );

  snoop_dp #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .snoopAddr  (snoopAddr),
    .invReq     (invReq),
    .tagHit     (tagHit),
    .tagState   (tagState),
    .cbValid    (cbValid),
    .cbAddr     (cbAddr),
    .modHit     (modHit),
    .lookupAddr (lookupAddr),
    .hitMod     (hitMod),
    .wbReq      (wbReq),
    .wbFromBuf  (wbFromBuf),
    .updValid   (updValid),
    .updAddr    (updAddr),
    .updState   (updState)
  );
endmodule

// File: rtl/snoop_inquiry_chk.sv
module snoop_inquiry_chk (
  input logic clk,
  input logic rstN,
  input logic holdReq,
  input logic holdAck,
  input logic backOff,
  input logic addrHold,
  input logic extStrobeN,
  input logic lookupEn,
  input logic wbDone,
  input logic hitMod,
  input logic wbReq,
  input logic updValid
);
  // R2
  legal_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lookupEn) |-> $past(!extStrobeN && ((holdReq && holdAck) || backOff || addrHold)));

  // R3
  lookup_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupEn |=> !lookupEn);

  // R4
  hit_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hitMod) |-> $past(lookupEn, 2));

  // R6
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> !updValid);

  // R6
  upd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> $past(lookupEn, 2));

  // R7
  wb_with_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hitMod) |-> wbReq);

  // R7
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitMod && !wbDone) |=> hitMod);

  // R7
  hit_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitMod && wbDone) |=> (!hitMod && !wbReq));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitMod |=> !lookupEn);
endmodule

bind snoop_inquiry_resp snoop_inquiry_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .holdReq    (holdReq),
  .holdAck    (holdAck),
  .backOff    (backOff),
  .addrHold   (addrHold),
  .extStrobeN (extStrobeN),
  .lookupEn   (lookupEn),
  .wbDone     (wbDone),
  .hitMod     (hitMod),
  .wbReq      (wbReq),
  .updValid   (updValid)
);

// File: tb/snoop_inquiry_resp_tb.sv
module snoop_inquiry_resp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int OW = 4;
  localparam int LW = AW - OW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdReq = 0, holdAck = 0, backOff = 0, addrHold = 0;
  logic extStrobeN = 1, invReq = 0;
  logic [AW-1:0] snoopAddr = '0;
  logic tagHit = 0;
  logic [1:0] tagState = 2'b00;
  logic cbValid = 0;
  logic [AW-1:0] cbAddr = '0;
  logic wbDone = 0;
  logic lookupEn, hitMod, wbReq, wbFromBuf, updValid;
  logic [LW-1:0] lookupAddr, updAddr;
  logic [1:0] updState;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_inquiry_resp #(.ADDR_W(AW), .OFFSET_W(OW)) dut_i (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .holdAck(holdAck),
    .backOff(backOff), .addrHold(addrHold), .extStrobeN(extStrobeN),
    .invReq(invReq), .snoopAddr(snoopAddr), .lookupEn(lookupEn),
    .lookupAddr(lookupAddr), .tagHit(tagHit), .tagState(tagState),
    .cbValid(cbValid), .cbAddr(cbAddr), .wbDone(wbDone), .hitMod(hitMod),
    .wbReq(wbReq), .wbFromBuf(wbFromBuf), .updValid(updValid),
    .updAddr(updAddr), .updState(updState)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit expLegal(bit h, bit ha, bit bo, bit ah);
    return (h && ha) || bo || ah;
  endfunction

  function automatic bit expBufHit(bit cv, logic [AW-1:0] ca, logic [AW-1:0] sa);
    return cv && (ca[AW-1:OW] == sa[AW-1:OW]);
  endfunction

  task automatic runInq(input bit h, input bit ha, input bit bo, input bit ah,
                        input logic [AW-1:0] addr, input bit inv,
                        input bit th, input logic [1:0] ts,
                        input bit cv, input logic [AW-1:0] ca,
                        input int waitCyc, input bit poke);
    bit legal, cacheMod, bufHit, modE, updE;
    legal    = expLegal(h, ha, bo, ah);
    cacheMod = th && (ts == 2'b11);
    bufHit   = expBufHit(cv, ca, addr);
    modE     = legal && (cacheMod || bufHit);
    updE     = legal && th;
    @(negedge clk);
    holdReq = h; holdAck = ha; backOff = bo; addrHold = ah;
    extStrobeN = 0; snoopAddr = addr; invReq = inv; cbValid = cv; cbAddr = ca;
    @(negedge clk);
    extStrobeN = 1; invReq = ~inv;  // R9: late change must not matter
    chk("R2/R3", "lookupEn", lookupEn, legal);
    if (legal) chk("R3", "lookupAddr", lookupAddr, addr[AW-1:OW]);
    tagHit = th; tagState = ts;
    wbDone = poke;  // R10: nothing pending
    @(negedge clk);
    chk("R3", "lookupEn single", lookupEn, 0);
    chk("R4", "hitMod early", hitMod, 0);
    tagHit = 1'($urandom); tagState = 2'($urandom); cbValid = 1'($urandom);
    wbDone = 0;
    if (poke) extStrobeN = 0;  // R8: strobe during result cycle
    @(negedge clk);
    extStrobeN = 1;
    chk("R4", "hitMod", hitMod, modE);
    chk("R7", "wbReq", wbReq, modE);
    if (modE) chk("R7/R5", "wbFromBuf", wbFromBuf, bufHit && !cacheMod);
    chk("R6", "updValid", updValid, updE);
    if (updE) begin
      chk("R6", "updAddr", updAddr, addr[AW-1:OW]);
      chk("R6/R9", "updState", updState, inv ? 2'b00 : 2'b01);
    end
    chk("R8", "lookupEn busy", lookupEn, 0);
    if (modE) begin
      for (int i = 0; i < waitCyc; i++) begin
        extStrobeN = poke ? 1'b0 : 1'b1;
        @(negedge clk);
        chk("R7", "hitMod held", hitMod, 1);
        chk("R7", "wbReq held", wbReq, 1);
        chk("R8", "lookupEn during wait", lookupEn, 0);
        chk("R6", "updValid one shot", updValid, 0);
      end
      extStrobeN = 1; wbDone = 1;
      @(negedge clk);
      wbDone = 0;
      chk("R7", "hitMod release", hitMod, 0);
      chk("R7", "wbReq release", wbReq, 0);
      chk("R8", "lookupEn after wait", lookupEn, 0);
    end else begin
      wbDone = poke;
      @(negedge clk);
      wbDone = 0;
      chk("R6", "updValid one shot", updValid, 0);
      chk("R10", "hitMod stray done", hitMod, 0);
      chk("R10", "wbReq stray done", wbReq, 0);
      chk("R8", "lookupEn ignored", lookupEn, 0);
    end
    holdReq = 0; holdAck = 0; backOff = 0; addrHold = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "lookupEn", lookupEn, 0);
    chk("R1", "hitMod", hitMod, 0);
    chk("R1", "wbReq", wbReq, 0);
    chk("R1", "wbFromBuf", wbFromBuf, 0);
    chk("R1", "updValid", updValid, 0);

    // R2 each legal condition, and illegal ones
    runInq(1, 1, 0, 0, 32'hA000_0010, 1, 1, 2'b11, 0, '0, 3, 1);
    runInq(0, 0, 1, 0, 32'hA000_0020, 0, 1, 2'b10, 0, '0, 0, 1);
    runInq(0, 0, 0, 1, 32'hA000_0030, 0, 1, 2'b01, 0, '0, 0, 0);
    runInq(1, 0, 0, 0, 32'hA000_0040, 1, 1, 2'b11, 0, '0, 2, 1);
    runInq(0, 1, 0, 0, 32'hA000_0050, 1, 1, 2'b11, 0, '0, 2, 0);
    // R4/R6 modified read keeps line shared after write-back
    runInq(0, 0, 0, 1, 32'h0BAD_0F00, 0, 1, 2'b11, 0, '0, 5, 1);
    // R4 tag miss, nothing
    runInq(0, 0, 1, 0, 32'h0000_1230, 1, 0, 2'b11, 0, '0, 0, 1);
    // R5 buffer match ignoring offset bits
    runInq(0, 0, 1, 0, 32'h1234_5670, 1, 0, 2'b00, 1, 32'h1234_567F, 1, 1);
    // R5 buffer one line bit away, and buffer invalid
    runInq(0, 0, 1, 0, 32'h1234_5670, 1, 0, 2'b00, 1, 32'h1234_5660, 0, 0);
    runInq(0, 0, 1, 0, 32'h1234_5670, 1, 0, 2'b00, 0, 32'h1234_5670, 0, 0);
    // R7 both cache and buffer match: source is cache
    runInq(1, 1, 0, 0, 32'h7777_0000, 1, 1, 2'b11, 1, 32'h7777_0008, 0, 1);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a, ca;
      bit sameLine;
      a = $urandom;
      sameLine = ($urandom % 4) == 0;
      ca = sameLine ? {a[AW-1:OW], 4'($urandom)} : $urandom;
      runInq(1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0,
             a, 1'($urandom), 1'($urandom), 2'($urandom),
             1'($urandom), ca, int'($urandom % 6), 1'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule